// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This peripheral drives four pulse-width-modulated outputs from one clock. Each channel holds three 32-bit words: a control word with a run bit and a 14-bit clock divider, a high-time count, and a cycle-length count. The channel divides the clock by (divider+1). It then counts divided ticks across the cycle length and drives its output high for the first high-time ticks. A single chip-wide run bit gates all four channels together, and each channel is also switched on its own.

Software reaches the words through a single-cycle port made of a byte address, a write strobe, write data and registered read data. Divider, high-time and cycle-length values go into shadow copies only when a cycle ends, or while the channel is stopped. A live waveform therefore never shows a partial or mixed cycle.

Top module: `pwm_bank`

## Requirements
- R1: While and after a synchronous reset, all outputs are low and every register reads zero.
- R2: Channel n (0 to 3) has its words at byte offset 16·n: control at +0x0, high-time at +0x4, cycle length at +0x8. The global run bit is bit 0 of the word at 0x3C, and the other bits of that word read zero.
- R3: In the control word, bit 0 is the channel run bit and bits [15:2] are the divider. Bits [31:16] and bit 1 read zero, and both fields can be rewritten together from a word read back earlier. High-time and cycle-length keep 16 bits. Read data is registered: it shows the addressed word as it stood before the edge that samples the address.
- R4: Offsets +0xC of channels 0 to 2, offsets that are not a multiple of four, and offsets at 0x40 and above read zero. Writes to them change no register.
- R5: A channel runs only while both the global run bit and its own run bit are set. Otherwise its output is low.
- R6: A running channel with divider P, high-time D and cycle length N repeats every (P+1)·N clocks. It is high for the first (P+1)·D clocks of each cycle.
- R7: If D ≥ N, the output stays high for the whole cycle. If D = 0, it stays low. N = 0 behaves as N = 1.
- R8: A new divider, high-time or cycle length written while a channel runs takes effect only at the next cycle boundary.
- R9: Stopping a channel clears its counters. The clock edge after a write that starts it again begins a fresh cycle, so the output goes high one clock after that edge when D > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for read and write |
| wr_en | input | 1 | Write strobe for wr_data at addr |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for addr |
| pwm_o | output | 4 | One waveform output per channel |

## Verification
The bench rewrites high-time and cycle length in the middle of a cycle. A design without shadowing would show a truncated or stretched cycle there. The bench also drives high-time equal to, above and at zero against the cycle length, where an off-by-one comparison shows a one-tick spike or a missing pulse. It toggles the global and per-channel run bits in the middle of a cycle to catch counters that are not cleared on stop, which would restart part-way through a cycle. It writes all-ones to reserved bits and unmapped offsets, where loose decoding would alias into a neighbouring channel or read back junk.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // word select inside a 16-byte channel window (addr[3:2])
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_GAP  = 2'd3
  } word_sel_e;

  localparam int DEF_PSC_W = 14;
  localparam int DEF_CNT_W = 16;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PSC_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_live,
  input  logic [CNT_W-1:0] high_live,
  input  logic [CNT_W-1:0] len_live,
  output logic             pwm
);
  logic [PSC_W-1:0] psc_sh;
  logic [CNT_W-1:0] high_sh;
  logic [CNT_W-1:0] len_sh;
  logic [CNT_W-1:0] pos_q;
  logic             tick;
  logic             last;

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .limit (psc_sh),
    .tick  (tick)
  );

  // a zero length wraps on every tick, like a length of one
  assign last = ({1'b0, pos_q} + 1'b1) >= {1'b0, len_sh};

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_sh  <= '0;
      high_sh <= '0;
      len_sh  <= '0;
      pos_q   <= '0;
      pwm     <= 1'b0;
    end else begin
      pwm <= run && (pos_q < high_sh);
      if (!run || (tick && last)) begin
        pos_q   <= '0;
        psc_sh  <= psc_live;
        high_sh <= high_live;
        len_sh  <= len_live;
      end else if (tick) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PSC_W = DEF_PSC_W,
  parameter int CNT_W = DEF_CNT_W,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_o
);
  localparam int CH_W = 2;
  localparam int PSC_LSB = 2;
  localparam int PSC_MSB = PSC_LSB + PSC_W - 1;
  localparam logic [AW-1:0] GLOBAL_ADDR = AW'(8'h3C);

  logic [NCH-1:0]            ch_run;
  logic [NCH-1:0][PSC_W-1:0] ch_psc;
  logic [NCH-1:0][CNT_W-1:0] ch_high;
  logic [NCH-1:0][CNT_W-1:0] ch_len;
  logic                      global_run;
  logic [DW-1:0]             rd_next;

  logic [CH_W-1:0] a_ch;
  word_sel_e       a_sel;
  logic            win_ok;
  logic            chan_hit;
  logic            global_hit;
  logic            wdata_unused;

  assign a_ch       = addr[5:4];
  assign a_sel      = word_sel_e'(addr[3:2]);
  assign win_ok     = (addr[AW-1:6] == '0) && (addr[1:0] == 2'b00);
  assign chan_hit   = win_ok && (int'(a_ch) < NCH) && (a_sel != SEL_GAP);
  assign global_hit = (addr == GLOBAL_ADDR);
  assign wdata_unused = ^{wr_data[DW-1:PSC_MSB+1], wr_data[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      global_run <= 1'b0;
    end else if (wr_en && global_hit) begin
      global_run <= wr_data[0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && chan_hit && (int'(a_ch) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        ch_run[g]  <= 1'b0;
        ch_psc[g]  <= '0;
        ch_high[g] <= '0;
        ch_len[g]  <= '0;
      end else if (hit) begin
        case (a_sel)
          SEL_CTRL: begin
            ch_run[g] <= wr_data[0];
            ch_psc[g] <= wr_data[PSC_MSB:PSC_LSB];
          end
          SEL_HIGH: ch_high[g] <= wr_data[CNT_W-1:0];
          SEL_LEN:  ch_len[g]  <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    pwm_chan #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .run       (global_run & ch_run[g]),
      .psc_live  (ch_psc[g]),
      .high_live (ch_high[g]),
      .len_live  (ch_len[g]),
      .pwm       (pwm_o[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (global_hit) begin
      rd_next[0] = global_run;
    end else if (chan_hit) begin
      case (a_sel)
        SEL_CTRL: begin
          rd_next[0]               = ch_run[a_ch];
          rd_next[PSC_MSB:PSC_LSB] = ch_psc[a_ch];
        end
        SEL_HIGH: rd_next[CNT_W-1:0] = ch_high[a_ch];
        SEL_LEN:  rd_next[CNT_W-1:0] = ch_len[a_ch];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  rd_data,
  input logic [NCH-1:0] pwm_o,
  input logic           global_run
);
  logic is_global;
  logic is_ctrl;
  logic is_unmapped;

  assign is_global   = (addr == AW'(8'h3C));
  assign is_ctrl     = (addr[AW-1:6] == '0) && (addr[3:0] == 4'h0);
  assign is_unmapped = !is_global &&
                       ((addr[AW-1:6] != '0) || (addr[1:0] != 2'b00) || (addr[3:2] == 2'b11));

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pwm_o == '0) && (rd_data == '0)); // R1

  AST_GLOBAL_WORD: assert property (@(posedge clk) disable iff (rst)
    is_global |=> (rd_data[DW-1:1] == '0)); // R2

  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (rst)
    is_ctrl |=> (rd_data[DW-1:16] == '0) && !rd_data[1]); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_unmapped |=> (rd_data == '0)); // R4

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !global_run |=> (pwm_o == '0)); // R5
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .rd_data    (rd_data),
  .pwm_o      (pwm_o),
  .global_run (global_run)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_o;

  always #5 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_o   (pwm_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    live = 0;
  string tag = "R1";

  // reference state: live registers, shadows, position within cycle
  int          m_glob;
  int          m_en[4], m_psc[4], m_high[4], m_len[4];
  int          s_psc[4], s_high[4], s_len[4];
  longint      m_pos[4];
  logic [3:0]  exp_pwm;
  logic [31:0] exp_rd;

  function automatic logic [31:0] mread(int a);
    int ch, w;
    if (a == 'h3C) return 32'(m_glob);
    if (a >= 'h40 || (a % 4) != 0) return 0;
    ch = a / 16;
    w  = (a % 16) / 4;
    case (w)
      0: return 32'((m_psc[ch] << 2) | m_en[ch]);
      1: return 32'(m_high[ch]);
      2: return 32'(m_len[ch]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_glob = 0;
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_psc[c] = 0; m_high[c] = 0; m_len[c] = 0;
        s_psc[c] = 0; s_high[c] = 0; s_len[c] = 0; m_pos[c] = 0;
      end
      exp_pwm = '0;
      exp_rd  = '0;
      live    = 1;
    end else begin
      exp_rd = mread(int'(addr));
      for (int c = 0; c < 4; c++) begin
        bit run;
        longint span;
        run = (m_glob != 0) && (m_en[c] != 0);
        exp_pwm[c] = run && (m_pos[c] < longint'(s_psc[c] + 1) * s_high[c]);
        span = longint'(s_psc[c] + 1) * ((s_len[c] == 0) ? 1 : s_len[c]);
        if (run) m_pos[c]++;
        if (!run || m_pos[c] >= span) begin
          m_pos[c] = 0;
          s_psc[c] = m_psc[c]; s_high[c] = m_high[c]; s_len[c] = m_len[c];
        end
      end
      if (wr_en) begin
        int a, ch;
        a = int'(addr);
        ch = a / 16;
        if (a == 'h3C) m_glob = int'(wr_data[0]);
        else if (a < 'h40 && (a % 4) == 0) begin
          case ((a % 16) / 4)
            0: begin m_en[ch] = int'(wr_data[0]); m_psc[ch] = int'(wr_data[15:2]); end
            1: m_high[ch] = int'(wr_data[15:0]);
            2: m_len[ch]  = int'(wr_data[15:0]);
            default: ;
          endcase
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      n_vec++;
      if (pwm_o !== exp_pwm) begin
        n_bad++;
        $display("FAIL %s pwm_o=%b expected %b at %0t", tag, pwm_o, exp_pwm, $time);
      end
      n_vec++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s rd_data=%h expected %h at %0t", tag, rd_data, exp_rd, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int psc, input int en);
    return 32'((psc << 2) | en);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, every word reads zero
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 'h40; a += 4) rd(8'(a));

    // R2 R3: map and field layout, reserved bits read zero
    tag = "R3";
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hABCD_1234);
    wr(8'h08, 32'h5555_0007);
    wr(8'h10, ctl(3, 0));
    wr(8'h24, 32'h0000_0042);
    wr(8'h38, 32'h0000_0099);
    for (int a = 0; a < 'h40; a += 4) rd(8'(a));
    tag = "R2";
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C);
    wr(8'h3C, 32'h0);
    rd(8'h3C);

    // R4: unmapped offsets read zero and leave every register unchanged
    tag = "R4";
    foreach (addr[i]) begin end
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h0C); rd(8'h2C); rd(8'h40); rd(8'h06); rd(8'hFC);
    for (int a = 0; a < 'h40; a += 4) rd(8'(a));

    // R5: channels enabled but the global bit clear keep outputs low
    tag = "R5";
    wr(8'h00, ctl(0, 1)); wr(8'h04, 2); wr(8'h08, 5);
    wr(8'h10, ctl(2, 1)); wr(8'h14, 1); wr(8'h18, 4);
    wr(8'h20, ctl(1, 1)); wr(8'h24, 3); wr(8'h28, 3);
    wr(8'h30, ctl(0, 1)); wr(8'h34, 0); wr(8'h38, 4);
    idle(20);

    // R6: periods and high times under several dividers
    tag = "R6";
    wr(8'h3C, 1);
    idle(80);

    // R7: high-time over length, zero high-time, zero length
    tag = "R7";
    wr(8'h24, 9);
    wr(8'h30, ctl(1, 1)); wr(8'h34, 1); wr(8'h38, 0);
    idle(40);
    wr(8'h34, 0);
    idle(20);

    // R8: mid-cycle rewrites wait for the cycle boundary
    tag = "R8";
    idle(5);
    wr(8'h14, 3); wr(8'h18, 5);
    idle(30);
    wr(8'h10, ctl(0, 1));
    idle(3);
    wr(8'h04, 4); wr(8'h08, 6);
    idle(40);

    // R9: stop mid-cycle, then restart with a fresh cycle
    tag = "R9";
    idle(3);
    wr(8'h00, ctl(0, 0));
    idle(6);
    wr(8'h00, ctl(0, 1));
    idle(20);
    wr(8'h3C, 0);
    idle(5);
    wr(8'h3C, 1);
    idle(20);

    // R6: large divider over several cycles
    tag = "R6";
    wr(8'h20, ctl(100, 1)); wr(8'h24, 1); wr(8'h28, 3);
    idle(1000);
    wr(8'h20, ctl(16383, 1)); wr(8'h28, 2);
    idle(33000);

    done = 1;
    summary();
    $finish;
  end
endmodule